// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block is a purely combinational shifter for the second operand of an arithmetic unit. It takes a data word, a shift kind, an amount and an incoming carry flag. In the same cycle it returns the shifted word and the shifter carry-out, which is the last bit pushed out of the word. It offers logical left, logical right, arithmetic right, rotate right, and a one-position rotate right through the carry flag.

The amount comes from one of two sources. One is a short immediate field. The other is a full register value, of which only the low byte is used. Because a register can supply a byte amount, amounts from the word width up to 255 have defined results. Logical shifts then flush to zero, arithmetic right saturates to the sign, and rotate wraps modulo the width.

The block is instantiated in front of an adder. Whether the flags are written back is decided elsewhere.

Top module: `operand_shifter`

## Requirements
- R1: Kind code 0 is a logical left shift. Codes 5, 6 and 7 behave exactly like code 0. For an amount n from 1 to 31 the result is the operand times 2^n, truncated to 32 bits, with zeros in the vacated low bits. The carry-out is operand bit 32−n.
- R2: Kind code 1 is a logical right shift. For n from 1 to 31 the result is the unsigned operand divided by 2^n, with zeros in the vacated high bits. The carry-out is operand bit n−1.
- R3: Kind code 2 is an arithmetic right shift. For n from 1 to 31 the top n bits hold copies of operand bit 31 and the carry-out is operand bit n−1.
- R4: Kind code 3 is a rotate right. For an amount n that is not a multiple of 32, bits leaving at bit 0 re-enter at bit 31. The carry-out equals result bit 31.
- R5: Kind code 4 shifts right by exactly one position and places the incoming carry at bit 31. The carry-out is operand bit 0. Both amount inputs are ignored for this kind.
- R6: When `amt_from_reg_i` is 0 the amount is `imm_amt_i` (0 to 31) and `reg_amt_i` is ignored. When it is 1 the amount is `reg_amt_i[7:0]` and bits 31:8 of `reg_amt_i` are ignored.
- R7: For every kind except code 4, an amount of 0 returns the operand unchanged with carry-out equal to `carry_i`.
- R8: For logical shifts (codes 0, 1, 5, 6 and 7) an amount of 32 or more gives a zero result. At exactly 32 the carry-out is operand bit 0 for left shifts and operand bit 31 for right shifts. Above 32 the carry-out is 0.
- R9: For arithmetic right, an amount of 32 or more gives all bits equal to operand bit 31, and the carry-out equals operand bit 31.
- R10: For rotate right, an amount of 32 or more acts as the amount modulo 32. A nonzero multiple of 32 returns the operand unchanged, with carry-out equal to operand bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand word to be shifted |
| kind_i | input | 3 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate-through-carry, 5 to 7 alias of LSL |
| amt_from_reg_i | input | 1 | Amount source: 0 immediate, 1 register |
| imm_amt_i | input | 5 | Immediate shift amount |
| reg_amt_i | input | 32 | Register holding the amount in its low byte |
| carry_i | input | 1 | Incoming carry flag |
| res_o | output | 32 | Shifted result |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The hardest cases to reach are the amounts from 32 to 255. They exist only on the register path, and there the carry rules change between exactly 32 and anything larger. The stimulus drives all 256 register amounts for every kind code and both carry values. It does this across a set of edge and pseudo-random operands, with nonzero junk in the upper register bits and in the unused immediate field. A second sweep covers the immediate path with junk in the register, so that any leak between the two amount sources shows up as a mismatch.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4,
        SK_ASL = 3'd5
    } shift_kind_e;

endpackage

// File: rtl/shift_amt_sel.sv
module shift_amt_sel #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 5,
    parameter int AMT_W = 8
) (
    input  logic             from_reg,
    input  logic [IMM_W-1:0] imm_amt,
    input  logic [WIDTH-1:0] reg_val,
    output logic [AMT_W-1:0] amt,
    output logic             amt_zero,
    output logic             amt_at_width,
    output logic             amt_past_width
);
    logic unused_reg_hi;

    assign unused_reg_hi  = ^reg_val[WIDTH-1:AMT_W];
    assign amt            = from_reg ? reg_val[AMT_W-1:0] : AMT_W'(imm_amt);
    assign amt_zero       = (amt == '0);
    assign amt_at_width   = (amt == AMT_W'(WIDTH));
    assign amt_past_width = (amt >  AMT_W'(WIDTH));
endmodule

// File: rtl/ror_stages.sv
module ror_stages #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SHW-1:0]   rot,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] lvl [SHW+1];

    assign lvl[0] = din;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign lvl[s+1] = rot[s] ? {lvl[s][STEP-1:0], lvl[s][WIDTH-1:STEP]}
                                 : lvl[s];
    end

    assign dout = lvl[SHW];
endmodule

// File: rtl/edge_mask.sv
module edge_mask #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] keep_low,
    output logic [WIDTH-1:0] keep_high
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign keep_low[i]  = (int'(amt) + i) < WIDTH;
        assign keep_high[i] = int'(amt) <= i;
    end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
    import shifter_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 5,
    parameter int AMT_W = 8
) (
    input  logic [WIDTH-1:0]  opnd_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic              amt_from_reg_i,
    input  logic [IMM_W-1:0]  imm_amt_i,
    input  logic [WIDTH-1:0]  reg_amt_i,
    input  logic              carry_i,
    output logic [WIDTH-1:0]  res_o,
    output logic              carry_o
);
    localparam int SHW = $clog2(WIDTH);

    logic [AMT_W-1:0] amt;
    logic             amt_zero, amt_at_w, amt_past_w;
    logic [SHW-1:0]   amt_lo, rot_left, idx_right, rot_amt;
    logic             go_left;
    logic [WIDTH-1:0] rotated, keep_low, keep_high;
    logic             sign;

    shift_amt_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W), .AMT_W(AMT_W)) u_amt (
        .from_reg       (amt_from_reg_i),
        .imm_amt        (imm_amt_i),
        .reg_val        (reg_amt_i),
        .amt            (amt),
        .amt_zero       (amt_zero),
        .amt_at_width   (amt_at_w),
        .amt_past_width (amt_past_w)
    );

    assign amt_lo    = amt[SHW-1:0];
    assign rot_left  = SHW'(0) - amt_lo;
    assign idx_right = amt_lo - SHW'(1);
    assign sign      = opnd_i[WIDTH-1];

    always_comb begin
        unique case (kind_i)
            SK_LSR, SK_ASR, SK_ROR, SK_RRX: go_left = 1'b0;
            default:                        go_left = 1'b1;
        endcase
    end

    assign rot_amt = go_left ? rot_left : amt_lo;

    ror_stages #(.WIDTH(WIDTH)) u_rot (
        .din  (opnd_i),
        .rot  (rot_amt),
        .dout (rotated)
    );

    edge_mask #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_mask (
        .amt       (amt),
        .keep_low  (keep_low),
        .keep_high (keep_high)
    );

    always_comb begin
        res_o   = opnd_i;
        carry_o = carry_i;
        unique case (kind_i)
            SK_RRX: begin
                res_o   = {carry_i, opnd_i[WIDTH-1:1]};
                carry_o = opnd_i[0];
            end
            SK_LSR: if (!amt_zero) begin
                res_o   = rotated & keep_low;
                carry_o = amt_past_w ? 1'b0 :
                          amt_at_w   ? opnd_i[WIDTH-1] : opnd_i[idx_right];
            end
            SK_ASR: if (!amt_zero) begin
                res_o   = (rotated & keep_low) | ({WIDTH{sign}} & ~keep_low);
                carry_o = (amt_past_w || amt_at_w) ? sign : opnd_i[idx_right];
            end
            SK_ROR: if (!amt_zero) begin
                res_o   = rotated;
                carry_o = rotated[WIDTH-1];
            end
            default: if (!amt_zero) begin
                res_o   = rotated & keep_high;
                carry_o = amt_past_w ? 1'b0 :
                          amt_at_w   ? opnd_i[0] : opnd_i[rot_left];
            end
        endcase
    end
endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 5,
    parameter int AMT_W = 8
) (
    input logic [WIDTH-1:0] opnd_i,
    input logic [2:0]       kind_i,
    input logic             amt_from_reg_i,
    input logic [IMM_W-1:0] imm_amt_i,
    input logic [WIDTH-1:0] reg_amt_i,
    input logic             carry_i,
    input logic [WIDTH-1:0] res_o,
    input logic             carry_o
);
    int                      n;
    logic                    logical;
    logic signed [WIDTH-1:0] asr_ref;

    always_comb begin
        n       = amt_from_reg_i ? int'(reg_amt_i[AMT_W-1:0]) : int'(imm_amt_i);
        logical = (kind_i != 3'd2) && (kind_i != 3'd3) && (kind_i != 3'd4);
        asr_ref = $signed(opnd_i) >>> n;

        if (kind_i != 3'd4 && n == 0)
            assert_hold_zero_R7: assert (res_o == opnd_i && carry_o == carry_i);

        if (kind_i == 3'd4)
            assert_rrx_R5: assert (res_o[WIDTH-2:0] == opnd_i[WIDTH-1:1]
                                   && res_o[WIDTH-1] == carry_i
                                   && carry_o == opnd_i[0]);

        if (logical && kind_i != 3'd1 && n > 0 && n < WIDTH)
            assert_lsl_R1: assert (res_o == (opnd_i << n)
                                   && carry_o == opnd_i[WIDTH-n]);

        if (kind_i == 3'd1 && n > 0 && n < WIDTH)
            assert_lsr_R2: assert (res_o == (opnd_i >> n)
                                   && carry_o == opnd_i[n-1]);

        if (kind_i == 3'd2 && n > 0 && n < WIDTH)
            assert_asr_R3: assert (res_o == asr_ref && carry_o == opnd_i[n-1]);

        if (kind_i == 3'd3 && n > 0)
            assert_ror_R4: assert (carry_o == res_o[WIDTH-1]
                                   && $countones(res_o) == $countones(opnd_i));

        if (logical && n > WIDTH)
            assert_flush_R8: assert (res_o == '0 && carry_o == 1'b0);

        if (kind_i == 3'd2 && n >= WIDTH)
            assert_sat_R9: assert (res_o == {WIDTH{opnd_i[WIDTH-1]}}
                                   && carry_o == opnd_i[WIDTH-1]);
    end
endmodule

bind operand_shifter operand_shifter_chk #(
    .WIDTH(WIDTH), .IMM_W(IMM_W), .AMT_W(AMT_W)
) u_chk (
    .opnd_i         (opnd_i),
    .kind_i         (kind_i),
    .amt_from_reg_i (amt_from_reg_i),
    .imm_amt_i      (imm_amt_i),
    .reg_amt_i      (reg_amt_i),
    .carry_i        (carry_i),
    .res_o          (res_o),
    .carry_o        (carry_o)
);

// File: tb/operand_shifter_tb.sv
module operand_shifter_tb;
    localparam int W = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd = '0;
    logic [2:0]  kind = '0;
    logic        from_reg = 1'b0;
    logic [4:0]  imm = '0;
    logic [31:0] regv = '0;
    logic        cin = 1'b0;
    logic [31:0] res;
    logic        cout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    operand_shifter u_dut (
        .opnd_i         (opnd),
        .kind_i         (kind),
        .amt_from_reg_i (from_reg),
        .imm_amt_i      (imm),
        .reg_amt_i      (regv),
        .carry_i        (cin),
        .res_o          (res),
        .carry_o        (cout)
    );

    function automatic void model(input logic [31:0] x, input logic [2:0] k,
                                  input int n, input logic ci,
                                  output logic [31:0] r, output logic c);
        logic [63:0] t;
        int m;
        r = x;
        c = ci;
        if (k == 3'd4) begin
            r = {ci, x[31:1]};
            c = x[0];
        end else if (n != 0) begin
            case (k)
                3'd1: begin t = {x, 32'b0} >> n;            r = t[63:32]; c = t[31]; end
                3'd2: begin t = $signed({x, 32'b0}) >>> n;  r = t[63:32]; c = t[31]; end
                3'd3: begin
                    m = n % 32;
                    if (m != 0) r = (x >> m) | (x << (32 - m));
                    c = r[31];
                end
                default: begin t = {32'b0, x} << n;         r = t[31:0];  c = t[32]; end
            endcase
        end
    endfunction

    function automatic string tag_of(input logic [2:0] k, input int n);
        if (k == 3'd4) return "R5";
        if (n == 0)    return "R7";
        if (k == 3'd3) return (n >= 32) ? "R10" : "R4";
        if (k == 3'd2) return (n >= 32) ? "R9"  : "R3";
        if (n >= 32)   return "R8";
        return (k == 3'd1) ? "R2" : "R1";
    endfunction

    task automatic run_one(input logic [31:0] x, input logic [2:0] k,
                           input logic fr, input logic [4:0] im,
                           input logic [31:0] rv, input logic ci, input string pre);
        logic [31:0] er;
        logic        ec;
        int          n;
        @(posedge clk);
        opnd = x; kind = k; from_reg = fr; imm = im; regv = rv; cin = ci;
        n = fr ? int'(rv[7:0]) : int'(im);
        model(x, k, n, ci, er, ec);
        @(negedge clk);
        n_checks++;
        if (res !== er || cout !== ec) begin
            n_fail++;
            $display("FAIL %s%s x=%h kind=%0d n=%0d cin=%b: actual res=%h c=%b expected res=%h c=%b",
                     pre, tag_of(k, n), x, k, n, ci, res, cout, er, ec);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual still running, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] pats [16];
        logic [31:0] lfsr;
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_0000; pats[3] = 32'h0000_0001;
        pats[4] = 32'h7FFF_FFFF; pats[5] = 32'hA5A5_3C3C;
        pats[6] = 32'h1234_5678; pats[7] = 32'h8000_0001;
        lfsr = 32'hC0DE_1357;
        for (int p = 8; p < 16; p++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            pats[p] = lfsr;
        end

        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R7: reset-time idle inputs give a zero word and a zero carry
        @(negedge clk);
        n_checks++;
        if (res !== 32'h0 || cout !== 1'b0) begin
            n_fail++;
            $display("FAIL R7 idle: actual res=%h c=%b expected res=00000000 c=0", res, cout);
        end

        // R6: register-path sweep, upper register bits and the immediate carry junk
        for (int p = 0; p < 16; p++)
            for (int k = 0; k < 8; k++)
                for (int a = 0; a < 256; a++)
                    for (int c = 0; c < 2; c++)
                        run_one(pats[p], 3'(k), 1'b1, 5'(a * 7 + 3),
                                {pats[(p + 5) % 16][31:8] | 24'h1, 8'(a)}, c[0], "R6/");

        // R6: immediate-path sweep, register operand carries junk
        for (int p = 0; p < 16; p++)
            for (int k = 0; k < 8; k++)
                for (int a = 0; a < 32; a++)
                    for (int c = 0; c < 2; c++)
                        run_one(pats[p], 3'(k), 1'b0, 5'(a),
                                32'hFFFF_FF00 | 32'(255 - a), c[0], "R6/");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule